// File: doc/BRIEF.md
# External Bus Cycle Controller

This block runs the external memory read and write cycles of a 16-bit controller. The core hands it one transfer at a time over a valid/ready request channel. The block then shapes the cycle on the external pins: an address-latch pulse, an optional longer latch phase, an optional gap before the command, a read or write strobe of programmable length, and one closing cycle. The address and data can share one set of pins (multiplexed), or the address can have its own pins (demultiplexed). A READY input can stretch the command phase. It is taken either through one register (synchronous mode) or through two registers (asynchronous mode).

An external master can take the bus with a hold request. The block finishes any cycle that is already running. It then raises its hold acknowledge and stops driving all of its output enables. While the bus is away, a pending transfer raises a bus-request output so the other master knows the bus is wanted. When the hold request drops, the acknowledge falls one cycle later and normal operation resumes.

Back-pressure rules: `req_ready` is high only while the sequencer is idle, the bus is owned and no hold request is present. A transfer is taken on a clock edge where `req_valid` and `req_ready` are both high. The response channel has no ready: `rsp_valid` is a single-cycle pulse and the core must take it.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, `bus_ale` is 0, `bus_rd_n` and `bus_wr_n` are 1, `hold_ack` is 0, `rsp_valid` is 0, `bus_ad_oe` is 0, and `req_ready` is 1 when `hold_req` is low.
- R2: A transfer is accepted on edge N. `bus_ale` is then high for one cycle. The strobe (`bus_rd_n` for reads, `bus_wr_n` for writes) is low for `cfg_waits`+1 cycles when READY is not used. One closing cycle follows with both strobes high.
- R3: With `cfg_ext_ale`=1, `bus_ale` stays high for two cycles instead of one.
- R4: With `cfg_rw_dly`=1, exactly one cycle with `bus_ale` low and both strobes high comes between the latch phase and the strobe. With `cfg_rw_dly`=0 there is no such cycle.
- R5: With `cfg_mux`=1, `bus_ad_out` carries address bits 15:0 with `bus_ad_oe`=1 while `bus_ale` is high. During a write strobe it carries the write data. During a read strobe `bus_ad_oe` is 0.
- R6: With `cfg_mux`=0, `bus_addr` carries all 18 address bits for the whole cycle. `bus_ad_oe` is 0 in the latch phase and during reads, and 1 with the write data during a write strobe.
- R7: For a read, `rsp_rdata` equals `bus_ad_in` as sampled in the last strobe cycle. `rsp_valid` is high for exactly one cycle, the closing cycle, for reads and for writes.
- R8: With `cfg_rdy_en`=1 and `cfg_rdy_async`=0, the strobe ends only when the wait count is used up and the once-registered READY is high. If READY rises during strobe cycle j (counting from 0) after the wait count is used up, the strobe lasts j+2 cycles.
- R9: With `cfg_rdy_en`=1 and `cfg_rdy_async`=1, READY passes through two registers. The same stimulus as in R8 gives a strobe of j+3 cycles.
- R10: `bus_addr[17:16]` and `bus_bhe_n` (low when `req_bhi`=1) keep their values through the strobe and through the closing cycle after the strobe rises.
- R11: If `hold_req` rises during a cycle, the cycle completes unchanged. `hold_ack` rises on the edge after the first idle cycle. While `hold_ack` is 1, `bus_ctl_oe`, `bus_addr_oe` and `bus_ad_oe` are 0, and no strobe or ALE is active.
- R12: `bus_req` is high exactly when `hold_ack` and `req_valid` are both high. `hold_ack` falls on the edge after `hold_req` is seen low.
- R13: `req_ready` is 0 during a running cycle, while `hold_ack` is 1 and while `hold_req` is 1.
- R14: `bus_rd_n` and `bus_wr_n` are never low together, and neither is low while `bus_ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mux | input | 1 | 1: address/data share pins |
| cfg_ext_ale | input | 1 | 1: two-cycle latch phase |
| cfg_rw_dly | input | 1 | 1: one gap cycle before the strobe |
| cfg_waits | input | 4 | Wait states added to the strobe |
| cfg_rdy_en | input | 1 | 1: strobe also waits for READY |
| cfg_rdy_async | input | 1 | 1: READY through two registers |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Transfer can be accepted |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | 18 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_bhi | input | 1 | High byte enabled |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_bhe_n | output | 1 | High byte enable, active low |
| bus_addr | output | 18 | Address pins |
| bus_ad_out | output | 16 | Address/data pins, outgoing |
| bus_ad_in | input | 16 | Address/data pins, incoming |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_out |
| bus_addr_oe | output | 1 | Drive enable for bus_addr and bus_bhe_n |
| bus_ctl_oe | output | 1 | Drive enable for ALE and strobes |
| bus_ready | input | 1 | External READY, active high |
| hold_req | input | 1 | External master asks for the bus |
| hold_ack | output | 1 | Bus released |
| bus_req | output | 1 | Bus wanted back |

## Verification
The bench runs all eight combinations of bus type, latch length and gap. If one of these shapes were wired wrong, the measured latch length, the gap count or the captured address would differ from what the bench expects. The READY case raises the line for a single cycle in the middle of a strobe. A synchronizer with the wrong depth would then end the strobe one cycle early or late. A READY held high while wait states remain checks that wait states still set the length. The hold case raises the request in the middle of a cycle. A controller that granted at once would cut the strobe short. A controller that kept a pending transfer blocked after the hold dropped would never give the transfer back, and the bench would see it stall.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ALEX,
    ST_GAP,
    ST_CMD,
    ST_TAIL
  } xbus_state_e;

  typedef struct packed {
    logic mux;
    logic ale_ext;
    logic rw_gap;
    logic rdy_use;
  } xbus_shape_t;

endpackage

// File: rtl/xbus_rdy_sync.sv
module xbus_rdy_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_sel,
  input  logic bus_ready,
  output logic rdy_eff
);
  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[DEPTH-2:0], bus_ready};
  end

  // synchronous mode taps the first stage, asynchronous the last
  assign rdy_eff = async_sel ? chain[DEPTH-1] : chain[0];
endmodule

// File: rtl/xbus_arb.sv
module xbus_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic seq_idle,
  input  logic req_valid,
  output logic hold_ack,
  output logic bus_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 hold_ack <= 1'b0;
    else if (!hold_ack && hold_req && seq_idle) hold_ack <= 1'b1;
    else if (hold_ack && !hold_req)             hold_ack <= 1'b0;
  end

  assign bus_req = hold_ack && req_valid;
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int WW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              req_bhi,
  input  xbus_shape_t       shape,
  input  logic [WW-1:0]     waits,
  input  logic              rdy_eff,
  input  logic [DW-1:0]     ad_in,
  output logic              idle,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              bhe_n,
  output logic [AW-1:0]     addr_out,
  output logic [DW-1:0]     ad_out,
  output logic              ad_drive,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata
);
  localparam int HI_W = AW - DW;

  xbus_state_e  state;
  xbus_shape_t  cur_shape;
  logic [WW-1:0] cur_waits, wait_cnt;
  logic          cur_write, cur_bhi;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata, rdata_q;
  logic          cmd_done, in_cmd, in_cycle, latch_ph, data_ph;

  assign cmd_done = (wait_cnt == '0) && (!cur_shape.rdy_use || rdy_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_shape <= '0;
      cur_waits <= '0;
      wait_cnt  <= '0;
      cur_write <= 1'b0;
      cur_bhi   <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      rdata_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          cur_shape <= shape;
          cur_waits <= waits;
          cur_write <= req_write;
          cur_bhi   <= req_bhi;
          cur_addr  <= req_addr;
          cur_wdata <= req_wdata;
          state     <= ST_ADDR;
        end
        ST_ADDR: begin
          wait_cnt <= cur_waits;
          if (cur_shape.ale_ext)     state <= ST_ALEX;
          else if (cur_shape.rw_gap) state <= ST_GAP;
          else                       state <= ST_CMD;
        end
        ST_ALEX: begin
          wait_cnt <= cur_waits;
          state    <= cur_shape.rw_gap ? ST_GAP : ST_CMD;
        end
        ST_GAP: begin
          wait_cnt <= cur_waits;
          state    <= ST_CMD;
        end
        ST_CMD: begin
          if (cmd_done) begin
            state <= ST_TAIL;
            if (!cur_write) rdata_q <= ad_in;
          end else if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - WW'(1);
          end
        end
        ST_TAIL: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle     = (state == ST_IDLE);
  assign in_cycle = !idle;
  assign latch_ph = (state == ST_ADDR) || (state == ST_ALEX);
  assign in_cmd   = (state == ST_CMD);
  assign data_ph  = cur_write &&
                    ((state == ST_GAP) || (state == ST_CMD) || (state == ST_TAIL));

  assign ale       = latch_ph;
  assign rd_n      = !(in_cmd && !cur_write);
  assign wr_n      = !(in_cmd && cur_write);
  assign bhe_n     = !(in_cycle && cur_bhi);
  assign rsp_valid = (state == ST_TAIL);
  assign rsp_rdata = rdata_q;

  always_comb begin
    addr_out = '0;
    if (in_cycle)
      addr_out = cur_shape.mux ? {cur_addr[AW-1:AW-HI_W], {DW{1'b0}}} : cur_addr;
  end

  always_comb begin
    ad_out   = '0;
    ad_drive = 1'b0;
    if (latch_ph && cur_shape.mux) begin
      ad_out   = cur_addr[DW-1:0];
      ad_drive = 1'b1;
    end else if (data_ph) begin
      ad_out   = cur_wdata;
      ad_drive = 1'b1;
    end
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int AW        = 18,
  parameter int DW        = 16,
  parameter int WW        = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mux,
  input  logic          cfg_ext_ale,
  input  logic          cfg_rw_dly,
  input  logic [WW-1:0] cfg_waits,
  input  logic          cfg_rdy_en,
  input  logic          cfg_rdy_async,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_bhi,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          bus_ale,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic          bus_bhe_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_ad_out,
  input  logic [DW-1:0] bus_ad_in,
  output logic          bus_ad_oe,
  output logic          bus_addr_oe,
  output logic          bus_ctl_oe,
  input  logic          bus_ready,
  input  logic          hold_req,
  output logic          hold_ack,
  output logic          bus_req
);
  logic        seq_idle, ad_drive, rdy_eff, req_fire;
  xbus_shape_t shape;

  assign shape     = '{mux: cfg_mux, ale_ext: cfg_ext_ale, rw_gap: cfg_rw_dly, rdy_use: cfg_rdy_en};
  assign req_ready = seq_idle && !hold_ack && !hold_req;
  assign req_fire  = req_valid && req_ready;

  xbus_rdy_sync #(.DEPTH(SYNC_DEPTH)) u_rdy (
    .clk(clk), .rst_n(rst_n), .async_sel(cfg_rdy_async),
    .bus_ready(bus_ready), .rdy_eff(rdy_eff)
  );

  xbus_arb u_arb (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .seq_idle(seq_idle),
    .req_valid(req_valid), .hold_ack(hold_ack), .bus_req(bus_req)
  );

  xbus_seq #(.AW(AW), .DW(DW), .WW(WW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(req_fire),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_bhi(req_bhi),
    .shape(shape), .waits(cfg_waits), .rdy_eff(rdy_eff), .ad_in(bus_ad_in),
    .idle(seq_idle), .ale(bus_ale), .rd_n(bus_rd_n), .wr_n(bus_wr_n), .bhe_n(bus_bhe_n),
    .addr_out(bus_addr), .ad_out(bus_ad_out), .ad_drive(ad_drive),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign bus_ctl_oe  = !hold_ack;
  assign bus_addr_oe = !hold_ack;
  assign bus_ad_oe   = ad_drive && !hold_ack;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold_req,
  input logic          hold_ack,
  input logic          bus_req,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          bus_ale,
  input logic          bus_rd_n,
  input logic          bus_wr_n,
  input logic          bus_bhe_n,
  input logic          bus_addr_oe,
  input logic [AW-1:0] bus_addr
);
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n)); // R14

  AST_ALE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_rd_n && bus_wr_n)); // R14

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7

  AST_RD_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |-> (bus_addr_oe && $stable(bus_addr[AW-1:DW]) && $stable(bus_bhe_n))); // R10

  AST_WR_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> (bus_addr_oe && $stable(bus_addr[AW-1:DW]) && $stable(bus_bhe_n))); // R10

  AST_HLDA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (bus_rd_n && bus_wr_n && !bus_ale && !rsp_valid)); // R11

  AST_BREQ_WHEN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (hold_ack && req_valid)); // R12

  AST_HLDA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !hold_req) |=> !hold_ack); // R12

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_rd_n && bus_wr_n && !bus_ale && !rsp_valid && !hold_req)); // R13
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
  .bus_req(bus_req), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n),
  .bus_wr_n(bus_wr_n), .bus_bhe_n(bus_bhe_n), .bus_addr_oe(bus_addr_oe),
  .bus_addr(bus_addr)
);

// File: tb/tb_xbus_ctrl.sv
module tb_xbus_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_mux = 1'b1, cfg_ext_ale = 1'b0, cfg_rw_dly = 1'b0;
  logic [3:0] cfg_waits = 4'd0;
  logic cfg_rdy_en = 1'b0, cfg_rdy_async = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_bhi = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic bus_ale, bus_rd_n, bus_wr_n, bus_bhe_n, bus_ad_oe, bus_addr_oe, bus_ctl_oe;
  logic [17:0] bus_addr;
  logic [15:0] bus_ad_out, bus_ad_in;
  logic bus_ready = 1'b0, hold_req = 1'b0;
  logic hold_ack, bus_req;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [15:0] mem_lat = '0;

  always #5 clk = ~clk;

  xbus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_mux(cfg_mux), .cfg_ext_ale(cfg_ext_ale),
    .cfg_rw_dly(cfg_rw_dly), .cfg_waits(cfg_waits), .cfg_rdy_en(cfg_rdy_en),
    .cfg_rdy_async(cfg_rdy_async), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_bhi(req_bhi),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_bhe_n(bus_bhe_n), .bus_addr(bus_addr), .bus_ad_out(bus_ad_out),
    .bus_ad_in(bus_ad_in), .bus_ad_oe(bus_ad_oe), .bus_addr_oe(bus_addr_oe),
    .bus_ctl_oe(bus_ctl_oe), .bus_ready(bus_ready), .hold_req(hold_req),
    .hold_ack(hold_ack), .bus_req(bus_req)
  );

  // external memory model: read value derived from the latched address
  assign bus_ad_in = mem_lat ^ 16'h5A3C;

  typedef struct packed {
    logic        wr;
    logic [17:0] a;
    logic [15:0] d;
    logic        bh;
    int          ale_len;
    int          dly_len;
    int          cmd_len;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // ---------------- monitor ----------------
  bit in_cyc = 0, seen_cmd = 0, hi_chg = 0, lo_chg = 0, rd_oe_bad = 0, ale_oe_bad = 0, wd_oe = 0;
  int n_ale = 0, n_dly = 0, n_cmd = 0;
  logic [15:0] cap_addr, cap_wd;
  logic [1:0]  cap_hi;
  logic        cap_bhe;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_ale) begin
        if (!in_cyc) begin
          n_ale = 0; n_dly = 0; n_cmd = 0;
          hi_chg = 0; lo_chg = 0; rd_oe_bad = 0; ale_oe_bad = 0; wd_oe = 0;
        end
        in_cyc = 1;
        n_ale++;
        cap_addr = cfg_mux ? bus_ad_out : bus_addr[15:0];
        cap_hi   = bus_addr[17:16];
        cap_bhe  = bus_bhe_n;
        mem_lat  = cap_addr;
        if (bus_ad_oe != cfg_mux) ale_oe_bad = 1;
        chk(!req_ready, "R13 ready during cycle", 32'(req_ready), 0);
      end else if (in_cyc) begin
        if (!bus_rd_n || !bus_wr_n) begin
          seen_cmd = 1;
          n_cmd++;
          if (bus_addr[17:16] != cap_hi || bus_bhe_n != cap_bhe) hi_chg = 1;
          if (!cfg_mux && bus_addr[15:0] != cap_addr) lo_chg = 1;
          if (!bus_wr_n) begin cap_wd = bus_ad_out; wd_oe = bus_ad_oe; end
          else if (bus_ad_oe) rd_oe_bad = 1;
        end else if (!seen_cmd) begin
          n_dly++;
        end else begin
          exp_t e;
          if (bus_addr[17:16] != cap_hi || bus_bhe_n != cap_bhe || !bus_addr_oe) hi_chg = 1;
          if (exp_q.size() == 0) begin
            chk(0, "R2 unexpected cycle", 1, 0);
          end else begin
            e = exp_q.pop_front();
            chk(n_ale == e.ale_len, "R2 R3 ale length", 32'(n_ale), 32'(e.ale_len));
            chk(n_dly == e.dly_len, "R4 gap length", 32'(n_dly), 32'(e.dly_len));
            chk(n_cmd == e.cmd_len, "R2 R8 R9 strobe length", 32'(n_cmd), 32'(e.cmd_len));
            chk(cap_addr == e.a[15:0] && !lo_chg, "R5 R6 address", 32'(cap_addr), 32'(e.a[15:0]));
            chk(!ale_oe_bad, "R5 R6 latch-phase drive", 32'(ale_oe_bad), 0);
            chk(cap_hi == e.a[17:16] && !hi_chg, "R10 upper address held", 32'(cap_hi), 32'(e.a[17:16]));
            chk(cap_bhe == !e.bh, "R10 byte-high enable", 32'(cap_bhe), 32'(!e.bh));
            chk(rsp_valid, "R7 response in closing cycle", 32'(rsp_valid), 1);
            if (e.wr) begin
              chk(cap_wd == e.d && wd_oe, "R5 R6 write data", 32'(cap_wd), 32'(e.d));
            end else begin
              chk(!rd_oe_bad, "R5 R6 read turnaround", 32'(rd_oe_bad), 0);
              chk(rsp_rdata == (e.a[15:0] ^ 16'h5A3C), "R7 read data", 32'(rsp_rdata), 32'(e.a[15:0] ^ 16'h5A3C));
            end
          end
          in_cyc = 0;
          seen_cmd = 0;
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic xfer(input logic wr, input logic [17:0] a, input logic [15:0] d,
                      input logic bh, input int cmd_len);
    exp_t e;
    while (!req_ready) @(negedge clk);
    e.wr = wr; e.a = a; e.d = d; e.bh = bh;
    e.ale_len = cfg_ext_ale ? 2 : 1;
    e.dly_len = cfg_rw_dly ? 1 : 0;
    e.cmd_len = cmd_len;
    exp_q.push_back(e);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bhi = bh;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // READY pulse in strobe cycle 1 (counting from 0)
  task automatic ready_xfer(input int cmd_len);
    fork
      xfer(1'b0, 18'h1_0F0F, 16'h0, 1'b1, cmd_len);
      begin
        @(negedge clk);
        while (bus_rd_n) @(negedge clk);
        @(negedge clk);
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
      end
    join
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_ale && bus_rd_n && bus_wr_n, "R1 strobes idle", {bus_ale, bus_rd_n, bus_wr_n}, 3'b011);
    chk(!hold_ack && !rsp_valid && !bus_ad_oe, "R1 ack/resp/oe low", {hold_ack, rsp_valid, bus_ad_oe}, 0);
    chk(req_ready, "R1 ready after reset", 32'(req_ready), 1);

    // all cycle shapes on both bus types
    for (int m = 0; m < 2; m++)
      for (int x = 0; x < 2; x++)
        for (int g = 0; g < 2; g++) begin
          int w;
          logic [17:0] a;
          w = x + g;
          a = 18'h2_1234 + 18'(m * 4 + x * 2 + g) * 18'h0F1;
          cfg_mux = m[0]; cfg_ext_ale = x[0]; cfg_rw_dly = g[0]; cfg_waits = 4'(w);
          xfer(1'b1, a, 16'hC000 + 16'(m * 4 + x * 2 + g), x[0] ^ g[0], w + 1);
          xfer(1'b0, a ^ 18'h3_0055, 16'h0, !(x[0] ^ g[0]), w + 1);
        end

    // longer wait states
    cfg_mux = 1'b1; cfg_ext_ale = 1'b0; cfg_rw_dly = 1'b0; cfg_waits = 4'd3;
    xfer(1'b1, 18'h0_ABCD, 16'h1357, 1'b1, 4);

    // READY stretching: sync R8, async R9
    cfg_waits = 4'd0; cfg_rdy_en = 1'b1; cfg_rdy_async = 1'b0;
    ready_xfer(3); // R8
    cfg_rdy_async = 1'b1;
    ready_xfer(4); // R9
    // READY already high: wait states decide (R8 R9)
    bus_ready = 1'b1; cfg_waits = 4'd2;
    repeat (3) @(negedge clk);
    xfer(1'b0, 18'h2_4444, 16'h0, 1'b0, 3);
    cfg_rdy_async = 1'b0;
    xfer(1'b1, 18'h1_2222, 16'hBEEF, 1'b0, 3);
    bus_ready = 1'b0; cfg_rdy_en = 1'b0;

    // hold arriving mid-cycle: R11
    cfg_waits = 4'd3;
    fork
      xfer(1'b0, 18'h3_3C3C, 16'h0, 1'b1, 4);
      begin repeat (3) @(negedge clk); hold_req = 1'b1; end
    join
    begin
      int n;
      n = 0;
      while (!hold_ack && n < 6) begin @(negedge clk); n++; end
    end
    chk(hold_ack, "R11 bus released after cycle", 32'(hold_ack), 1);
    chk(exp_q.size() == 0, "R11 cycle completed first", 32'(exp_q.size()), 0);
    chk(!bus_ctl_oe && !bus_addr_oe && !bus_ad_oe, "R11 outputs released",
        {bus_ctl_oe, bus_addr_oe, bus_ad_oe}, 0);
    chk(!req_ready, "R13 no accept while released", 32'(req_ready), 0);
    chk(!bus_req, "R12 no bus request without work", 32'(bus_req), 0);

    // pending work raises bus_req, then regain: R12
    begin
      exp_t e;
      e.wr = 1'b1; e.a = 18'h0_7070; e.d = 16'h2468; e.bh = 1'b0;
      e.ale_len = 1; e.dly_len = 0; e.cmd_len = 4;
      exp_q.push_back(e);
    end
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h0_7070; req_wdata = 16'h2468; req_bhi = 1'b0;
    @(negedge clk);
    chk(bus_req, "R12 bus request while released", 32'(bus_req), 1);
    chk(!req_ready && !bus_ale, "R13 still blocked", {req_ready, bus_ale}, 0);
    hold_req = 1'b0;
    @(negedge clk);
    chk(!hold_ack, "R12 hold ack drops", 32'(hold_ack), 0);
    chk(!bus_req, "R12 bus request drops", 32'(bus_req), 0);
    chk(req_ready && bus_ctl_oe, "R13 ready after regain", {req_ready, bus_ctl_oe}, 2'b11);
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule